// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer Bank

This block holds a number of identical countdown timers behind one shared register port. Each timer has a main down-counter that steps once per prescaler underflow. The prescaler is a narrower down-counter that restarts from a programmable divide value. When the main counter is at zero and a step arrives, the counter restarts from its period register and a sticky event flag is set. That flag drives the timer's own interrupt line only while its interrupt enable is set.

Software reaches each timer through four word registers. The register address is the timer index followed by a two-bit register select. Writes take effect at the clock edge that samples them. Read data is registered and appears one cycle after the address is presented. Software can freeze a timer, force both of its counters to restart from their programmed values, and clear the event flag by writing one to it.

Top module: `cdt_timer_bank`

## Requirements
- R1: After reset every timer has period all ones, divide value 0, main count all ones, prescale count 0, stop 0, interrupt enable 0 and flag 0. `irq` and `rd_data` are 0.
- R2: `addr` = {timer index, select}. The select codes are 0 = main count (read only), 1 = period, 2 = divide (bits 15:0 read/write divide value, bits 31:16 read-only prescale count) and 3 = control. `rd_data` returns the addressed register one cycle later. An index with no timer behind it reads 0, and writes to it are ignored.
- R3: While running with divide value D, the main counter decrements once every D+1 clock cycles. The prescale count runs D, D-1, ..., 0 and then restarts at D.
- R4: A step that finds the main count at 0 loads the period P instead and sets the flag. From a restart to the flag, the delay is (P+1)(D+1) cycles.
- R5: Control bit 0 (stop) set to 1 freezes both the main counter and the prescale counter.
- R6: Writing 1 to control bit 1 loads the main counter from the period and the prescale counter from the divide value, whether the timer is stopped or running. Bit 1 always reads as 0.
- R7: Control bit 3 reads as the flag. Writing 1 to it clears the flag, and writing 0 leaves it unchanged. A flag-setting event in the same cycle wins over the clear.
- R8: Control bit 2 is the interrupt enable. `irq[i]` is a register equal to flag AND enable of timer i as they stood one cycle earlier.
- R9: Timers are independent: accesses and events of one timer never change another timer's registers or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (4) | {timer index, register select} |
| wdata | input | CNT_W (32) | Write data |
| rd_data | output | CNT_W (32) | Registered read data, one cycle after `addr` |
| irq | output | NUM_TIMERS (3) | Per-timer interrupt lines |

## Verification
A write acts on the edge that samples it. The first counter step after a restart comes D+1 edges later, the flag rises (P+1)(D+1) edges after the restart, and `irq` follows one further edge. The bench therefore counts falling edges from the restart write and expects the interrupt on exactly the (P+1)(D+1)+1-th one, checking it is still low the edge before. Reads are sampled at the falling edge after the edge that registered the address. Frozen counts are predicted by counting the running edges up to and including the edge that applies the stop write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DIVIDE = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTL_STOP   = 0;
  localparam int CTL_RELOAD = 1;
  localparam int CTL_IE     = 2;
  localparam int CTL_FLAG   = 3;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  // One step per underflow; a forced load pre-empts the step.
  assign tick = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= div;
    end else if (run) begin
      if (cnt == '0) cnt <= div;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period,
  output logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] psc_cnt,
  output logic             stop,
  output logic             ie,
  output logic             flag,
  output logic             reload_req,
  output logic             irq
);
  logic tick;
  logic wrap;
  logic wr_ctrl;

  assign wr_ctrl    = wr_en && (wr_sel == SEL_CTRL);
  assign reload_req = wr_ctrl && wr_data[CTL_RELOAD];
  assign wrap       = tick && (cnt == '0);

  cdt_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (!stop),
    .load (reload_req),
    .div  (div),
    .tick (tick),
    .cnt  (psc_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '1;
      div    <= '0;
      stop   <= 1'b0;
      ie     <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PERIOD: period <= wr_data;
        SEL_DIVIDE: div    <= wr_data[DIV_W-1:0];
        SEL_CTRL: begin
          stop <= wr_data[CTL_STOP];
          ie   <= wr_data[CTL_IE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (reload_req) begin
      cnt <= period;
    end else if (tick) begin
      if (wrap) cnt <= period;
      else      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wrap)                                flag <= 1'b1;
      else if (wr_ctrl && wr_data[CTL_FLAG])   flag <= 1'b0;
      irq <= flag && ie;
    end
  end
endmodule

// File: rtl/cdt_timer_bank.sv
module cdt_timer_bank
  import cdt_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 32,
  parameter int DIV_W      = 16,
  localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W    = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wdata,
  output logic [CNT_W-1:0]      rd_data,
  output logic [NUM_TIMERS-1:0] irq
);
  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;

  assign idx = addr[ADDR_W-1:2];
  assign sel = reg_sel_e'(addr[1:0]);

  logic [CNT_W-1:0]      ch_cnt    [NUM_TIMERS];
  logic [CNT_W-1:0]      ch_period [NUM_TIMERS];
  logic [DIV_W-1:0]      ch_div    [NUM_TIMERS];
  logic [DIV_W-1:0]      ch_psc    [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] ch_stop;
  logic [NUM_TIMERS-1:0] ch_ie;
  logic [NUM_TIMERS-1:0] ch_flag;
  logic [NUM_TIMERS-1:0] ch_reload;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && (idx == IDX_W'(g));

    cdt_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (ch_wr),
      .wr_sel     (sel),
      .wr_data    (wdata),
      .cnt        (ch_cnt[g]),
      .period     (ch_period[g]),
      .div        (ch_div[g]),
      .psc_cnt    (ch_psc[g]),
      .stop       (ch_stop[g]),
      .ie         (ch_ie[g]),
      .flag       (ch_flag[g]),
      .reload_req (ch_reload[g]),
      .irq        (irq[g])
    );
  end

  logic [CNT_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (idx == IDX_W'(i)) begin
        case (sel)
          SEL_COUNT:  rd_next = ch_cnt[i];
          SEL_PERIOD: rd_next = ch_period[i];
          SEL_DIVIDE: rd_next = CNT_W'({ch_psc[i], ch_div[i]});
          SEL_CTRL:   rd_next = CNT_W'({ch_flag[i], ch_ie[i], 1'b0, ch_stop[i]});
          default:    rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/cdt_timer_checker.sv
module cdt_timer_checker #(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_TIMERS-1:0] irq,
  input logic [CNT_W-1:0]      cnt    [NUM_TIMERS],
  input logic [CNT_W-1:0]      period [NUM_TIMERS],
  input logic [NUM_TIMERS-1:0] stop,
  input logic [NUM_TIMERS-1:0] ie,
  input logic [NUM_TIMERS-1:0] flag,
  input logic [NUM_TIMERS-1:0] reload
);
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    // R3 / R4: a count change is either a single step down or a wrap to the period
    a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
      (!$past(reload[g]) && (cnt[g] != $past(cnt[g]))) |->
        ((cnt[g] == $past(cnt[g]) - 1'b1) ||
         (($past(cnt[g]) == '0) && (cnt[g] == $past(period[g])))));

    // R4: the flag only rises when the counter was at zero
    a_r4_flag_from_zero: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[g]) |-> ($past(cnt[g]) == '0));

    // R5: a stopped timer holds its count unless a reload is forced
    a_r5_stop_freezes: assert property (@(posedge clk) disable iff (rst)
      ($past(stop[g]) && !$past(reload[g])) |-> $stable(cnt[g]));

    // R6: a forced reload lands the period in the counter
    a_r6_reload_loads: assert property (@(posedge clk) disable iff (rst)
      $past(reload[g]) |-> (cnt[g] == $past(period[g])));

    // R8: the interrupt line needs the enable and the flag of the previous cycle
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
      irq[g] |-> ($past(ie[g]) && $past(flag[g])));
  end
endmodule

bind cdt_timer_bank cdt_timer_checker #(
  .NUM_TIMERS(NUM_TIMERS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .cnt    (ch_cnt),
  .period (ch_period),
  .stop   (ch_stop),
  .ie     (ch_ie),
  .flag   (ch_flag),
  .reload (ch_reload)
);

// File: tb/cdt_timer_bank_test.sv
module cdt_timer_bank_test;
  localparam int N = 3;
  localparam logic [31:0] C_STOP = 32'h1, C_RLD = 32'h2, C_IE = 32'h4, C_CLR = 32'h8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [N-1:0] irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cdt_timer_bank #(.NUM_TIMERS(N), .CNT_W(32), .DIV_W(16)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [3:0] ra(input int t, input int s);
    return {2'(t), 2'(s)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Restart timer t with period p and divide dv, then count edges to the interrupt.
  task automatic run_to_irq(input string req, input int t, input logic [31:0] p, input int dv);
    int n = 0;
    int due = (int'(p) + 1) * (dv + 1) + 1;
    logic seen_early = 1'b0;
    wr(ra(t, 0) | 4'd3, C_STOP | C_CLR);
    wr(ra(t, 1), p);
    wr(ra(t, 2), 32'(dv));
    wr(ra(t, 3), C_RLD | C_IE | C_CLR);
    while (n < 1000) begin
      @(negedge clk);
      n++;
      if (irq[t]) break;
      if (n == due - 1) seen_early = irq[t];
    end
    chk({req, " irq delay"}, 32'(n), 32'(due));
    chk({req, " irq not early"}, {31'b0, seen_early}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rd_data reset", rd_data, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    rd(ra(0, 1), v); chk("R1 period reset", v, 32'hFFFF_FFFF);
    rd(ra(0, 2), v); chk("R1 divide reset", v, 32'h0);
    rd(ra(0, 3), v); chk("R1 ctrl reset", v, 32'h0);
  endtask

  task automatic t_divide_one;
    run_to_irq("R4 D=0", 0, 32'd3, 0);
  endtask

  task automatic t_prescaled;
    logic [31:0] v;
    run_to_irq("R4 D=2", 0, 32'd4, 2);
    rd(ra(0, 3), v); chk("R7 flag visible", v & C_CLR, C_CLR);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(ra(0, 3), C_STOP | C_IE);
    wr(ra(0, 3), C_STOP | C_IE | C_CLR);
    chk("R8 irq lags clear", 32'(irq[0]), 32'd1);
    @(negedge clk);
    chk("R7 irq after clear", 32'(irq[0]), 32'd0);
    rd(ra(0, 3), v); chk("R7 flag cleared", v, C_STOP | C_IE);
  endtask

  task automatic t_stop_count;
    logic [31:0] v1, v2;
    wr(ra(0, 3), C_STOP | C_CLR);
    wr(ra(0, 1), 32'd50);
    wr(ra(0, 2), 32'd3);
    wr(ra(0, 3), C_RLD);
    repeat (18) @(negedge clk);
    wr(ra(0, 3), C_STOP);
    rd(ra(0, 0), v1); chk("R3 count after 20 edges", v1, 32'd45);
    rd(ra(0, 2), v1); chk("R3 prescale phase", v1, {16'd3, 16'd3});
    repeat (7) @(negedge clk);
    rd(ra(0, 0), v2); chk("R5 count frozen", v2, 32'd45);
    rd(ra(0, 2), v2); chk("R5 prescale frozen", v2, {16'd3, 16'd3});
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(ra(0, 1), 32'd100);
    wr(ra(0, 3), C_STOP | C_RLD);
    rd(ra(0, 0), v); chk("R6 reload while stopped", v, 32'd100);
    rd(ra(0, 3), v); chk("R6 reload bit reads 0", v, C_STOP);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    logic any = 1'b0;
    wr(ra(0, 3), C_STOP | C_CLR);
    wr(ra(0, 1), 32'd2);
    wr(ra(0, 2), 32'd0);
    wr(ra(0, 3), C_RLD);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      any = any | irq[0];
    end
    chk("R8 no irq without enable", 32'(any), 32'd0);
    wr(ra(0, 3), C_STOP);
    rd(ra(0, 3), v); chk("R4 flag set while disabled", v, C_STOP | C_CLR);
    wr(ra(0, 3), C_STOP | C_IE);
    chk("R8 irq one cycle after enable", 32'(irq[0]), 32'd0);
    @(negedge clk);
    chk("R8 irq follows enable", 32'(irq[0]), 32'd1);
    wr(ra(0, 3), C_STOP | C_CLR);
  endtask

  task automatic t_independent;
    logic [31:0] v;
    run_to_irq("R9 timer1", 1, 32'd3, 1);
    chk("R9 only timer1 irq", 32'(irq), 32'b010);
    rd(ra(0, 1), v); chk("R9 timer0 period kept", v, 32'd2);
    wr(ra(1, 3), C_STOP | C_CLR);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(ra(3, 1), 32'hFFFF_0000);
    rd(ra(3, 1), v); chk("R2 empty index reads 0", v, 32'h0);
    rd(ra(2, 1), v); chk("R2 timer2 untouched", v, 32'hFFFF_FFFF);
    wr(ra(2, 2), 32'h0000_0007);
    rd(ra(2, 2), v); chk("R2 divide low field", v & 32'hFFFF, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_divide_one();
    t_prescaled();
    t_clear();
    t_stop_count();
    t_reload();
    t_gate();
    t_independent();
    t_decode();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule